// File: doc/BRIEF.md
# PCI Master DMA Request Sequencer

This block sits between a backend and the master request side of a 32-bit PCI master core and runs one DMA transfer at a time. A single-cycle start pulse supplies a 4-bit bus command, a start address, a word count and an active-low byte-enable value. The block then presents a fixed command to the core and raises a burst request. It keeps that request up until the last word has moved, and then drops it at the one point in time the core accepts as the end of the transaction.

Two address pointers are maintained. The write pointer advances by one 32-bit word on each bus-side transfer strobe. The read pointer advances on each backend delivery strobe. For writes, data comes out of a small local FIFO that the backend fills. The FIFO head is offered to the core with a valid flag, and the core's ready acknowledge pops the head. When the request is released, a one-cycle completion pulse marks the end of the transfer.

Top module: `dma_req_seq`

## Requirements
- R1: Start codes 4'b0000, 4'b0010, 4'b0110, 4'b1010, 4'b1100 and 4'b1110 are accepted as reads. From the cycle after the start pulse, `burst_req` is 1 and `pci_cmd` equals the code.
- R2: Start codes 4'b0001, 4'b0011, 4'b0111, 4'b1011 and 4'b1111 are accepted as writes. From the cycle after the start pulse, `burst_req` is 1 and `pci_cmd` equals the code.
- R3: A start whose code is any of the five remaining values, or whose word count is zero, is rejected. `burst_req` stays 0 and no `done` pulse follows.
- R4: `pci_cmd` does not change on any cycle in which `burst_req` is held high.
- R5: A down-counter loaded with the word count decrements once per strobe of the active direction: `xfer_strobe` for writes, `rd_data_valid` for reads. The strobe of the other direction does not move it. Take T as the cycle in which the last strobe is seen. `burst_req` is still 1 in cycle T+1 and is 0 from cycle T+2.
- R6: On a write start, `wr_addr` loads the start address. It then grows by 4 on every cycle where `xfer_strobe` is high while the write is running, and holds otherwise.
- R7: On a read start, `rd_addr` loads the start address. It then grows by 4 on every cycle where `rd_data_valid` is high while the read is running. `wr_addr` keeps its value during a read.
- R8: `byte_en_n` (active-low, 0 enables a lane) takes the start value and holds it for the whole request.
- R9: `wr_data_valid` is 1 exactly when a write is running and the local FIFO is not empty. A word leaves the FIFO only on a cycle with `wr_data_valid` and `wr_data_rdy` both 1, and words leave in the order they were written.
- R10: `done` is high for exactly one cycle, the first cycle in which `burst_req` is 0 after a transfer.
- R11: A start pulse while `burst_req` is 1, including the cycle after the last strobe, has no effect on command, addresses, count or release timing.
- R12: After reset, `burst_req`, `done` and `wr_data_valid` are 0 and `fill_ready` is 1 (FIFO empty).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Start pulse for a new transfer |
| start_cmd | input | 4 | Bus command for the transfer |
| start_addr | input | 32 | Byte start address |
| start_words | input | 16 | Number of 32-bit words to move |
| start_be_n | input | 4 | Active-low byte enables for the transfer |
| fill_valid | input | 1 | Backend offers a word to the local FIFO |
| fill_data | input | 32 | Word offered to the local FIFO |
| fill_ready | output | 1 | Local FIFO has room |
| pci_cmd | output | 4 | Command presented to the core |
| burst_req | output | 1 | Burst request to the core |
| wr_addr | output | 32 | Write address for the core |
| rd_addr | output | 32 | Read address for the core |
| wr_data | output | 32 | Write data word (FIFO head) |
| byte_en_n | output | 4 | Active-low byte enables |
| wr_data_valid | output | 1 | Write data word is valid |
| wr_data_rdy | input | 1 | Core acknowledges the write data word |
| xfer_strobe | input | 1 | A data phase completed on the bus |
| rd_data_valid | input | 1 | Core delivers a read word to the backend |
| done | output | 1 | One-cycle pulse when the request drops |

## Verification
The bench counts cycles around the final strobe. A design that released the request one cycle early or one cycle late would show up at cycle T+1 or T+2. Read transfers are interleaved with bus-side strobes. A design that counted or stepped addresses on the wrong strobe would end the read early, or would move `rd_addr` or `wr_addr` when it should not. Every one of the sixteen command codes is tried, together with a zero word count, which exposes a wrong read, write or reject decode. Start pulses are placed mid-burst and in the tail cycle, and `wr_data_rdy` is asserted while idle. A design that restarted, changed its command or popped a word without valid would then show a wrong command, a late release or out-of-order data.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    CK_READ  = 2'd0,
    CK_WRITE = 2'd1,
    CK_BAD   = 2'd2
  } cmd_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2
  } seq_state_e;

  // Direction of a 4-bit bus command; unlisted codes are refused.
  function automatic cmd_kind_e classify_cmd(input logic [3:0] code);
    cmd_kind_e k;
    case (code)
      4'b0000, 4'b0010, 4'b0110,
      4'b1010, 4'b1100, 4'b1110: k = CK_READ;
      4'b0001, 4'b0011, 4'b0111,
      4'b1011, 4'b1111:          k = CK_WRITE;
      default:                   k = CK_BAD;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/dma_seq_fifo.sv
module dma_seq_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_en,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_en,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0]    cnt_q, cnt_n;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    if (p == PW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  always_comb begin
    wp_n  = push_en ? bump(wp_q) : wp_q;
    rp_n  = pop_en  ? bump(rp_q) : rp_q;
    cnt_n = cnt_q;
    case ({push_en, pop_en})
      2'b10:   cnt_n = cnt_q + 1'b1;
      2'b01:   cnt_n = cnt_q - 1'b1;
      default: cnt_n = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_en) mem[wp_q] <= push_data;
  end

  assign head  = mem[rp_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));

  // R9: the consumer never pops an empty FIFO, the producer never overfills it
  p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |-> !empty);
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> (!full || pop_en));

endmodule

// File: rtl/dma_seq_addr.sv
module dma_seq_addr #(
  parameter int unsigned AW   = 32,
  parameter int unsigned STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          adv,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] addr_q, addr_n;

  always_comb begin
    addr_n = addr_q;
    if (load)     addr_n = load_val;
    else if (adv) addr_n = addr_q + AW'(STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_n;
  end

  assign addr = addr_q;

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       start_cmd,
  input  logic [CNT_W-1:0] start_words,
  input  logic             xfer_strobe,
  input  logic             rd_valid,
  output logic             accept,
  output logic             accept_write,
  output logic             run,
  output logic             dir_write,
  output logic [3:0]       cmd,
  output logic             burst_req,
  output logic             done
);
  seq_state_e       st_q, st_n;
  logic [CNT_W-1:0] rem_q, rem_n;
  logic [3:0]       cmd_q, cmd_n;
  logic             wr_q, wr_n;
  logic             done_q, done_n;
  cmd_kind_e        kind;
  logic             step, last;

  always_comb begin
    kind         = classify_cmd(start_cmd);
    accept       = (st_q == ST_IDLE) && start && (kind != CK_BAD) && (start_words != '0);
    accept_write = (kind == CK_WRITE);
    step         = (st_q == ST_RUN) && (wr_q ? xfer_strobe : rd_valid);
    last         = step && (rem_q == CNT_W'(1));

    st_n   = st_q;
    rem_n  = rem_q;
    cmd_n  = cmd_q;
    wr_n   = wr_q;
    done_n = 1'b0;
    case (st_q)
      ST_IDLE: if (accept) begin
        st_n  = ST_RUN;
        rem_n = start_words;
        cmd_n = start_cmd;
        wr_n  = accept_write;
      end
      ST_RUN: begin
        if (step) rem_n = rem_q - 1'b1;
        if (last) st_n  = ST_TAIL;
      end
      ST_TAIL: begin
        st_n   = ST_IDLE;
        done_n = 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rem_q  <= '0;
      cmd_q  <= '0;
      wr_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      rem_q  <= rem_n;
      cmd_q  <= cmd_n;
      wr_q   <= wr_n;
      done_q <= done_n;
    end
  end

  assign run       = (st_q == ST_RUN);
  assign dir_write = wr_q;
  assign cmd       = cmd_q;
  assign burst_req = (st_q != ST_IDLE);
  assign done      = done_q;

  // R4: command frozen while the request is held
  p_cmd_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_req && $past(burst_req)) |-> $stable(cmd));
  // R5: request survives the cycle after the last strobe
  p_hold_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> burst_req);
  // R5: request gone in the second cycle after the last strobe
  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TAIL) |=> !burst_req);
  // R10: completion is a single-cycle pulse that coincides with release
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!burst_req || $past(!burst_req)) ##1 !done);
  // R3: refused start raises nothing
  p_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_IDLE) && start && (kind == CK_BAD)) |=> !burst_req);
  // R11: a start in the tail cycle does not restart the block
  p_tail_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_TAIL) && start) |=> !burst_req);

endmodule

// File: rtl/dma_req_seq.sv
module dma_req_seq
  import dma_seq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [3:0]          start_cmd,
  input  logic [ADDR_W-1:0]   start_addr,
  input  logic [CNT_W-1:0]    start_words,
  input  logic [DATA_W/8-1:0] start_be_n,
  input  logic                fill_valid,
  input  logic [DATA_W-1:0]   fill_data,
  output logic                fill_ready,
  output logic [3:0]          pci_cmd,
  output logic                burst_req,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W/8-1:0] byte_en_n,
  output logic                wr_data_valid,
  input  logic                wr_data_rdy,
  input  logic                xfer_strobe,
  input  logic                rd_data_valid,
  output logic                done
);
  localparam int unsigned LANES = DATA_W / 8;
  localparam int unsigned STEP  = LANES;
  localparam int unsigned NPTR  = 2;   // index 0: write pointer, 1: read pointer

  logic accept, accept_write, run, dir_write;
  logic fifo_empty, fifo_full, push_en, pop_en;
  logic [LANES-1:0]  be_q, be_n;
  logic [NPTR-1:0]   ld, adv;
  logic [ADDR_W-1:0] ptr_q [NPTR];

  dma_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .start_cmd    (start_cmd),
    .start_words  (start_words),
    .xfer_strobe  (xfer_strobe),
    .rd_valid     (rd_data_valid),
    .accept       (accept),
    .accept_write (accept_write),
    .run          (run),
    .dir_write    (dir_write),
    .cmd          (pci_cmd),
    .burst_req    (burst_req),
    .done         (done)
  );

  assign push_en       = fill_valid && !fifo_full;
  assign wr_data_valid = run && dir_write && !fifo_empty;
  assign pop_en        = wr_data_valid && wr_data_rdy;
  assign fill_ready    = !fifo_full;

  dma_seq_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (push_en),
    .push_data (fill_data),
    .pop_en    (pop_en),
    .head      (wr_data),
    .empty     (fifo_empty),
    .full      (fifo_full)
  );

  assign ld[0]  = accept && accept_write;
  assign ld[1]  = accept && !accept_write;
  assign adv[0] = run && dir_write && xfer_strobe;
  assign adv[1] = run && !dir_write && rd_data_valid;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    dma_seq_addr #(.AW(ADDR_W), .STEP(STEP)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld[g]),
      .load_val (start_addr),
      .adv      (adv[g]),
      .addr     (ptr_q[g])
    );
  end

  assign wr_addr = ptr_q[0];
  assign rd_addr = ptr_q[1];

  always_comb begin
    be_n = be_q;
    if (accept) be_n = start_be_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) be_q <= '1;
    else        be_q <= be_n;
  end

  assign byte_en_n = be_q;

  // R6: write pointer steps one word per bus transfer of a write
  p_wr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && dir_write && xfer_strobe) |=> (wr_addr == $past(wr_addr) + ADDR_W'(STEP)));
  // R7: write pointer untouched during a read
  p_wr_frozen_in_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !dir_write) |=> $stable(wr_addr));
  // R8: byte enables fixed while the request is held
  p_be_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_req && $past(burst_req)) |-> $stable(byte_en_n));
  // R9: write data only offered inside a request
  p_valid_in_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_valid |-> burst_req);

endmodule

// File: tb/tb_dma_req_seq.sv
`timescale 1ns/1ps
module tb_dma_req_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [3:0]  start_cmd;
  logic [31:0] start_addr;
  logic [15:0] start_words;
  logic [3:0]  start_be_n;
  logic        fill_valid;
  logic [31:0] fill_data;
  logic        fill_ready;
  logic [3:0]  pci_cmd;
  logic        burst_req;
  logic [31:0] wr_addr, rd_addr, wr_data;
  logic [3:0]  byte_en_n;
  logic        wr_data_valid, wr_data_rdy, xfer_strobe, rd_data_valid, done;

  int checks = 0;
  int errors = 0;

  dma_req_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_cmd(start_cmd),
    .start_addr(start_addr), .start_words(start_words), .start_be_n(start_be_n),
    .fill_valid(fill_valid), .fill_data(fill_data), .fill_ready(fill_ready),
    .pci_cmd(pci_cmd), .burst_req(burst_req), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .wr_data(wr_data), .byte_en_n(byte_en_n), .wr_data_valid(wr_data_valid),
    .wr_data_rdy(wr_data_rdy), .xfer_strobe(xfer_strobe),
    .rd_data_valid(rd_data_valid), .done(done)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  // 0 refused, 1 read, 2 write (from R1, R2, R3)
  function automatic int kind_of(input logic [3:0] c);
    case (c)
      4'b0000, 4'b0010, 4'b0110, 4'b1010, 4'b1100, 4'b1110: return 1;
      4'b0001, 4'b0011, 4'b0111, 4'b1011, 4'b1111:          return 2;
      default: return 0;
    endcase
  endfunction

  task automatic drive_start(input logic [3:0] c, input logic [31:0] a,
                             input logic [15:0] n, input logic [3:0] be);
    start = 1'b1; start_cmd = c; start_addr = a; start_words = n; start_be_n = be;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 0; start_cmd = 0; start_addr = 0; start_words = 0;
    start_be_n = 4'hF; fill_valid = 0; fill_data = 0; wr_data_rdy = 0;
    xfer_strobe = 0; rd_data_valid = 0;
    repeat (3) nxt();
    rst_n = 1'b1;
    nxt();
    chk("R12 burst_req", 32'(burst_req), 0);
    chk("R12 done", 32'(done), 0);
    chk("R12 wr_data_valid", 32'(wr_data_valid), 0);
    chk("R12 fill_ready", 32'(fill_ready), 1);
  endtask

  task automatic t_write_burst();
    logic [31:0] w [3];
    logic [31:0] base;
    base = 32'h0000_1000;
    w[0] = 32'hA0A0_0001; w[1] = 32'hB1B1_0002; w[2] = 32'hC2C2_0003;
    for (int i = 0; i < 3; i++) begin
      chk("R9 fill_ready before push", 32'(fill_ready), 1);
      fill_valid = 1'b1; fill_data = w[i];
      nxt();
    end
    fill_valid = 1'b0;
    // R9: idle with data queued, valid low, a ready pulse must not pop
    chk("R9 valid low while idle", 32'(wr_data_valid), 0);
    wr_data_rdy = 1'b1;
    nxt();
    wr_data_rdy = 1'b0;
    drive_start(4'b0111, base, 16'd3, 4'b1010);
    nxt();
    // R11: start while busy with another command
    drive_start(4'b0110, 32'hDEAD_0000, 16'd9, 4'b0000);
    chk("R2 burst_req up", 32'(burst_req), 1);
    chk("R2 pci_cmd", 32'(pci_cmd), 32'h7);
    chk("R6 wr_addr loaded", wr_addr, base);
    chk("R8 byte_en_n", 32'(byte_en_n), 32'hA);
    chk("R9 valid in write", 32'(wr_data_valid), 1);
    chk("R9 first word kept", wr_data, w[0]);
    nxt();
    start = 1'b0;
    chk("R11 cmd unchanged", 32'(pci_cmd), 32'h7);
    chk("R11 be unchanged", 32'(byte_en_n), 32'hA);
    chk("R6 wr_addr holds without strobe", wr_addr, base);
    for (int i = 0; i < 3; i++) begin
      chk("R5 request held", 32'(burst_req), 1);
      chk("R9 data order", wr_data, w[i]);
      chk("R6 wr_addr step", wr_addr, base + 32'(4 * i));
      chk("R4 cmd stable", 32'(pci_cmd), 32'h7);
      wr_data_rdy = 1'b1; xfer_strobe = 1'b1;
      nxt();
      wr_data_rdy = 1'b0; xfer_strobe = 1'b0;
    end
    // cycle T+1
    chk("R5 held at T+1", 32'(burst_req), 1);
    chk("R10 no done at T+1", 32'(done), 0);
    chk("R9 valid low when FIFO drained", 32'(wr_data_valid), 0);
    chk("R6 wr_addr final", wr_addr, base + 32'd12);
    drive_start(4'b0110, 32'h5555_0000, 16'd1, 4'b0000);  // R11 tail start
    nxt();
    start = 1'b0;
    chk("R5 released at T+2", 32'(burst_req), 0);
    chk("R10 done at release", 32'(done), 1);
    nxt();
    chk("R10 done single cycle", 32'(done), 0);
    chk("R11 tail start ignored", 32'(burst_req), 0);
  endtask

  task automatic t_read_burst();
    logic [31:0] base;
    base = 32'h2000_0040;
    drive_start(4'b0110, base, 16'd3, 4'b0001);
    nxt();
    start = 1'b0;
    chk("R1 burst_req up", 32'(burst_req), 1);
    chk("R1 pci_cmd", 32'(pci_cmd), 32'h6);
    chk("R7 rd_addr loaded", rd_addr, base);
    chk("R8 byte_en_n read", 32'(byte_en_n), 32'h1);
    chk("R9 no write valid in read", 32'(wr_data_valid), 0);
    xfer_strobe = 1'b1; wr_data_rdy = 1'b1;
    nxt(); nxt();
    xfer_strobe = 1'b0; wr_data_rdy = 1'b0;
    chk("R7 rd_addr ignores bus strobe", rd_addr, base);
    chk("R7 wr_addr frozen in read", wr_addr, 32'h0000_100C);
    for (int i = 0; i < 3; i++) begin
      chk("R5 read request held", 32'(burst_req), 1);
      chk("R7 rd_addr step", rd_addr, base + 32'(4 * i));
      rd_data_valid = 1'b1;
      nxt();
      rd_data_valid = 1'b0;
    end
    chk("R5 read held at T+1", 32'(burst_req), 1);
    chk("R7 rd_addr final", rd_addr, base + 32'd12);
    nxt();
    chk("R5 read released at T+2", 32'(burst_req), 0);
    chk("R10 read done", 32'(done), 1);
    nxt();
    chk("R10 read done single", 32'(done), 0);
    chk("R7 wr_addr after read", wr_addr, 32'h0000_100C);
  endtask

  task automatic t_reject();
    logic [3:0] bad [5];
    bad[0] = 4'b0100; bad[1] = 4'b0101; bad[2] = 4'b1000; bad[3] = 4'b1001; bad[4] = 4'b1101;
    for (int i = 0; i < 5; i++) begin
      drive_start(bad[i], 32'h3000_0000, 16'd2, 4'b0000);
      nxt();
      start = 1'b0;
      chk("R3 bad code no request", 32'(burst_req), 0);
      nxt();
      chk("R3 bad code no done", 32'(done), 0);
    end
    drive_start(4'b0111, 32'h3000_0000, 16'd0, 4'b0000);
    nxt();
    start = 1'b0;
    chk("R3 zero count no request", 32'(burst_req), 0);
    chk("R3 zero count wr_addr untouched", wr_addr, 32'h0000_100C);
    nxt();
    chk("R3 zero count no done", 32'(done), 0);
  endtask

  task automatic t_all_codes();
    for (int c = 0; c < 16; c++) begin
      int k;
      k = kind_of(4'(c));
      drive_start(4'(c), 32'(c * 16), 16'd1, 4'b1100);
      nxt();
      start = 1'b0;
      if (k == 0) begin
        chk("R3 code decode", 32'(burst_req), 0);
        nxt();
        chk("R3 code no done", 32'(done), 0);
      end else begin
        chk(k == 1 ? "R1 code decode" : "R2 code decode", 32'(burst_req), 1);
        chk(k == 1 ? "R1 code echo" : "R2 code echo", 32'(pci_cmd), 32'(c));
        if (k == 1) rd_data_valid = 1'b1; else xfer_strobe = 1'b1;
        nxt();
        rd_data_valid = 1'b0; xfer_strobe = 1'b0;
        chk("R5 single word held", 32'(burst_req), 1);
        nxt();
        chk("R5 single word released", 32'(burst_req), 0);
        chk("R10 single word done", 32'(done), 1);
        nxt();
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_write_burst();
    t_read_burst();
    t_reject();
    t_all_codes();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule